// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures an intermediate-frequency signal by counting its rising edges over a fixed gate window. Software or a neighbouring control block sets a start bit. The block first runs a settling wait. It then opens the gate for the selected time and raises a done flag. The accumulated count stays on the output until the start bit is cleared. Clearing the start bit at any point aborts the measurement and returns the counter to zero.

A two-bit gate code picks one of four gate lengths. The settling wait is tied to that choice: short gates get a short wait and long gates get a long one. All timing is derived from a timebase clock, and the parameter `CLKS_PER_MS` gives the number of those clocks per millisecond. An inhibit input from the reference block freezes the whole measurement while it is high. The IF input is asynchronous to the timebase and is synchronized inside the block.

Top module: `ifc_gated_counter`

## Requirements
- R1: While `start_en` is 0, the block returns to idle. `done` reads 0 from the following cycle, and `count_out` reads 0 no later than two cycles after `start_en` is sampled low.
- R2: The gate window lasts G timebase cycles, where G = 4, 8, 32 or 64 times `CLKS_PER_MS` for gate code 2'b00, 2'b01, 2'b10 or 2'b11 respectively.
- R3: The settling wait lasts W cycles, with W = 4·`CLKS_PER_MS` for codes 2'b00 and 2'b01 and W = 8·`CLKS_PER_MS` for codes 2'b10 and 2'b11. With no inhibit, `done` is first seen high W+G cycles after the first clock edge that samples `start_en` = 1.
- R4: Rising edges of `if_in` are counted only inside the gate window. Each pulse that stays high and low for at least two cycles counts exactly once, and edges that arrive during the wait are not counted.
- R5: Once `done` is high, it stays high and `count_out` holds its value for as long as `start_en` stays 1.
- R6: The counter saturates at 2^`CNT_W`−1 and never wraps.
- R7: Each cycle that `inhibit` is high freezes both the wait/gate timer and the counter, and `if_in` edges seen during inhibit are not counted. The result is that `done` is delayed by exactly the number of inhibited cycles.
- R8: `gate_sel` is captured when a measurement starts. Changing it during the measurement has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| start_en | input | 1 | 1 starts and holds a measurement, 0 aborts and clears |
| gate_sel | input | 2 | Gate length code, captured at start |
| inhibit | input | 1 | Freezes the timer and counter while high |
| if_in | input | 1 | Asynchronous IF input whose rising edges are counted |
| count_out | output | CNT_W | Edge count of the current or last measurement |
| done | output | 1 | High once the gate has closed, until `start_en` is cleared |

## Verification
The bench places bursts of pulses in the settling wait and in the gate window, and checks the exact cycle at which `done` rises for every gate code. A design with the wait/gate pairing swapped, or an off-by-one timer, shows up as a shifted `done` cycle, and one that counts during the wait reports too high a count. Inhibit is asserted over a burst in mid-gate. A design that ignores inhibit counts those pulses and finishes early. A long burst drives the counter past full scale, where a wrapping counter would report a small value. Two further cases change the gate code after start, which would shorten or stretch the window if it were not captured, and abort a measurement part-way, where stale counts or a spurious `done` would remain.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } ifc_state_e;

    // Control handed from the sequencer to the edge counter.
    typedef struct packed {
        logic clr;
        logic en;
    } ifc_cnt_ctl_t;

    localparam int unsigned IFC_MAX_MS = 64;

    function automatic int unsigned ifc_gate_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 4;
            2'b01:   return 8;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int unsigned ifc_wait_ms(input logic [1:0] code);
        return code[1] ? 8 : 4;
    endfunction

endpackage

// File: rtl/ifc_sync_edge.sv
module ifc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], d_async};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~prev_q;

    // R4: an edge pulse lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
    import ifc_pkg::*;
#(
    parameter int CLKS_PER_MS = 1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_en,
    input  logic         inhibit,
    input  logic [1:0]   gate_sel,
    output ifc_cnt_ctl_t ctl,
    output logic         done
);
    localparam int TW = $clog2(IFC_MAX_MS * CLKS_PER_MS + 1);

    ifc_state_e    st_q;
    logic [TW-1:0] timer_q;
    logic [1:0]    code_q;
    logic [TW-1:0] wait_lim;
    logic [TW-1:0] gate_lim;

    assign wait_lim = TW'(ifc_wait_ms(code_q) * CLKS_PER_MS);
    assign gate_lim = TW'(ifc_gate_ms(code_q) * CLKS_PER_MS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            timer_q <= '0;
            code_q  <= 2'b00;
        end else if (!start_en) begin
            st_q    <= ST_IDLE;
            timer_q <= '0;
        end else if (!inhibit) begin
            case (st_q)
                ST_IDLE: begin
                    st_q    <= ST_WAIT;
                    timer_q <= '0;
                    code_q  <= gate_sel;
                end
                ST_WAIT: begin
                    if (timer_q == wait_lim - 1'b1) begin
                        st_q    <= ST_COUNT;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (timer_q == gate_lim - 1'b1) begin
                        st_q    <= ST_DONE;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: st_q <= ST_DONE;
            endcase
        end
    end

    always_comb begin
        ctl.clr = (st_q == ST_IDLE);
        ctl.en  = (st_q == ST_COUNT) && !inhibit;
    end
    assign done = (st_q == ST_DONE);

    // R7: inhibit freezes the sequencer
    a_r7_inhibit_freeze: assert property (@(posedge clk) disable iff (rst)
        (start_en && inhibit) |=> ($stable(st_q) && $stable(timer_q)));
    // R5: done is held while start stays set
    a_r5_done_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE && start_en) |=> (st_q == ST_DONE));
    // R1: clearing start returns to idle
    a_r1_idle_on_clear: assert property (@(posedge clk) disable iff (rst)
        !start_en |=> (st_q == ST_IDLE));
    // R3: wait timer stays inside its window
    a_r3_wait_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT) |-> (timer_q < wait_lim));
    // R2: gate timer stays inside its window
    a_r2_gate_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_COUNT) |-> (timer_q < gate_lim));
    // R8: captured gate code does not move mid-measurement
    a_r8_code_stable: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> $stable(code_q));

endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: full scale is sticky, no wrap to zero
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && !clr) |=> (cnt == FULL));
    // R4: value only moves when an edge is accepted or a clear occurs
    a_r4_hold_without_inc: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt));

endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
    import ifc_pkg::*;
#(
    parameter int CLKS_PER_MS = 1000,
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_en,
    input  logic [1:0]       gate_sel,
    input  logic             inhibit,
    input  logic             if_in,
    output logic [CNT_W-1:0] count_out,
    output logic             done
);
    ifc_cnt_ctl_t ctl;
    logic         if_rise;

    ifc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (if_in),
        .rise    (if_rise)
    );

    ifc_ctrl #(.CLKS_PER_MS(CLKS_PER_MS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_en (start_en),
        .inhibit  (inhibit),
        .gate_sel (gate_sel),
        .ctl      (ctl),
        .done     (done)
    );

    ifc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctl.clr),
        .inc (if_rise && ctl.en),
        .cnt (count_out)
    );

    // R1: done drops the cycle after start is cleared
    a_r1_done_clear: assert property (@(posedge clk) disable iff (rst)
        !start_en |=> !done);
    // R1: count reaches zero two cycles after start is cleared
    a_r1_count_clear: assert property (@(posedge clk) disable iff (rst)
        !start_en |=> ##1 (count_out == '0));
    // R7: an inhibited cycle leaves the count alone
    a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (inhibit && start_en && !ctl.clr) |=> $stable(count_out));

endmodule

// File: tb/tb_ifc_gated_counter.sv
module tb_ifc_gated_counter;
    localparam int CPM   = 20;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_en = 1'b0;
    logic [1:0]       gate_sel = 2'b00;
    logic             inhibit = 1'b0;
    logic             if_in = 1'b0;
    logic [CNT_W-1:0] count_out;
    logic             done;

    ifc_gated_counter #(.CLKS_PER_MS(CPM), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .start_en(start_en), .gate_sel(gate_sel),
        .inhibit(inhibit), .if_in(if_in), .count_out(count_out), .done(done)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    exp_cnt;
        int    exp_cyc;
        string tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    logic  done_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compares each done rising edge against the scoreboard
    always @(negedge clk) begin
        if (!rst && done && !done_prev) begin
            if (sb.size() == 0) begin
                check("R1 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " count"}, int'(count_out), it.exp_cnt);
                check({it.tag, " done cycle"}, cyc, it.exp_cyc);
            end
        end
        done_prev <= done;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        repeat (n) begin
            if_in = 1'b1; wait_cyc(2);
            if_in = 1'b0; wait_cyc(2);
        end
    endtask

    function automatic int gate_cycles(input logic [1:0] c);
        case (c)
            2'b00:   return 4 * CPM;
            2'b01:   return 8 * CPM;
            2'b10:   return 32 * CPM;
            default: return 64 * CPM;
        endcase
    endfunction

    function automatic int wait_cycles(input logic [1:0] c);
        return (c[1] ? 8 : 4) * CPM;
    endfunction

    // Driver: runs one measurement and pushes its expected result
    task automatic meas(input logic [1:0] code, input int nw, input int ng,
                        input int ninh, input int exp_cnt, input string tag,
                        input bit swap_gate);
        int    w, g, e0;
        item_t it;
        w  = wait_cycles(code);
        g  = gate_cycles(code);
        e0 = cyc + 1;
        it.exp_cnt = exp_cnt;
        it.exp_cyc = e0 + w + g + ninh;
        it.tag     = tag;
        sb.push_back(it);
        gate_sel = code;
        start_en = 1'b1;
        wait_cyc(5);
        if (swap_gate) gate_sel = ~code;
        pulses(nw);                      // wait-phase pulses must not count (R4)
        wait_until(e0 + w + 6);
        pulses(ng);
        if (ninh > 0) begin              // R7: pulses under inhibit are lost
            inhibit = 1'b1;
            wait_cyc(4);
            pulses(5);
            wait_cyc(ninh - 24);
            inhibit = 1'b0;
        end
        while (!done && cyc < e0 + w + g + ninh + 50) @(negedge clk);
        wait_cyc(20);
        check({tag, " R5 done held"}, int'(done), 1);
        check({tag, " R5 count held"}, int'(count_out), exp_cnt);
        start_en = 1'b0;
        wait_cyc(3);
        check({tag, " R1 count cleared"}, int'(count_out), 0);
        check({tag, " R1 done cleared"}, int'(done), 0);
        wait_cyc(5);
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        check("R1 reset count", int'(count_out), 0);
        check("R1 reset done", int'(done), 0);

        meas(2'b00, 10, 13, 0, 13, "R2 R3 R4 code00", 1'b0);
        meas(2'b01, 12, 29, 0, 29, "R2 R3 R4 code01", 1'b0);
        meas(2'b10, 8, 20, 40, 20, "R7 inhibit code10", 1'b0);
        meas(2'b11, 3, 100, 0, 63, "R6 saturation code11", 1'b0);
        meas(2'b00, 4, 7, 0, 7, "R8 gate change ignored", 1'b1);

        // Abort mid-gate: no done, counter returns to zero (R1)
        gate_sel = 2'b10;
        start_en = 1'b1;
        wait_cyc(wait_cycles(2'b10) + 10);
        pulses(5);
        check("R4 abort counted before clear", int'(count_out), 5);
        start_en = 1'b0;
        wait_cyc(3);
        check("R1 abort count", int'(count_out), 0);
        check("R1 abort done", int'(done), 0);
        wait_cyc(50);
        check("R1 scoreboard drained", sb.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule